// File: doc/BRIEF.md
# Synchronous SRAM Chip-Select and Burst Address Front-End

This block is the control front-end of a pipelined synchronous SRAM model. It decodes three chip selects. One select is fixed active-low. The other two are programmable selects, and a strap input sets the polarity of each one. A programmable select counts as active when its level equals its strap, so a strap of 1 makes it active high and a strap of 0 makes it active low. Four devices can share two address bits as select lines when their straps are set to the four binary codes. Exactly one of them then responds, with no glue logic.

A command cycle with `ld_cmd` high and all three selects active loads the address. Each cycle with `ld_cmd` low advances the burst counter. Only the two low address bits count, in linear order modulo 4, and the upper bits hold still. So after the loaded address the block presents three further addresses, and the fourth advance returns it to the loaded value.

Each access cycle produces a read-valid / data-drive enable two cycles later. An access cycle is a selected load, or one of the three advances that follow it. The echo-clock drive enable uses the same two-stage pipeline. It follows only the programmable selects: deselecting through the fixed select leaves the echo clocks running. A single enable gates both the true and the inverted echo-clock outputs.

Top module: `sram_frontend`

## Requirements
- R1: While reset is held, `addr_out` is 0, `rd_valid` is 0 and `echo_oe` is 0.
- R2: A cycle with `ld_cmd`=1 and all three selects active makes `addr_out` equal `addr_in` after that clock edge.
- R3: A cycle with `ld_cmd`=0 adds 1 modulo 4 to `addr_out[1:0]` at the next edge and keeps `addr_out[ADDR_W-1:2]` unchanged.
- R4: After a selected load of address A, the fourth advance returns `addr_out` to A, which is the fifth rising edge counting the load.
- R5: Programmable select i is active exactly when `sel_prog[i]` equals `pol_strap[i]`, so strap 1 means active high and strap 0 means active low.
- R6: A cycle with `ld_cmd`=1 and any select inactive leaves `addr_out` unchanged and produces no access.
- R7: `rd_valid` is high in the second cycle after each access cycle. An access cycle is a selected load, or one of the first three advances after it. `rd_valid` is low otherwise.
- R8: `echo_oe` is high in the second cycle after a cycle in which both programmable selects were active, and low otherwise. `sel_fixed_n` has no effect on it.
- R9: A selected load during a burst replaces the burst address and restarts the count of four accesses.
- R10: Four devices whose straps are 00, 01, 10 and 11 see the same two select levels, and exactly one of them accepts the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_cmd | input | 1 | 1 = load address (if selected), 0 = advance burst |
| addr_in | input | ADDR_W | Address to load |
| sel_fixed_n | input | 1 | Fixed active-low chip select |
| sel_prog | input | NPROG | Programmable chip selects |
| pol_strap | input | NPROG | Polarity straps, 1 = select active high |
| addr_out | output | ADDR_W | Internal array address |
| rd_valid | output | 1 | Read data valid / data driver enable |
| echo_oe | output | 1 | Drive enable for the true and inverted echo clocks |

## Verification
The assertions assume that every input holds a defined 0 or 1 at each sampled edge once the internal reset is released. They also assume the straps are driven like ordinary inputs, so a strap may change from one command cycle to the next. The echo-clock property compares against the select state two edges back, and it is armed only after two edges out of reset. The bench drives all inputs at the falling clock edge, only ever with defined values. It keeps most random cycles selected so that long bursts occur, and it injects deselects, strap changes and mid-burst loads at lower rates.

// File: rtl/sram_fe_pkg.sv
package sram_fe_pkg;
  // decoded select state for one command cycle
  typedef struct packed {
    logic prog_sel;  // all programmable selects match their straps
    logic all_sel;   // programmable selects and fixed select active
  } sel_t;
endpackage

// File: rtl/sram_fe_en_decode.sv
module sram_fe_en_decode
  import sram_fe_pkg::*;
#(
  parameter int NPROG = 2
) (
  input  logic             sel_fixed_n,
  input  logic [NPROG-1:0] sel_prog,
  input  logic [NPROG-1:0] pol_strap,
  output sel_t             sel
);
  logic [NPROG-1:0] hit;

  // each programmable select is active when it equals its strap level
  for (genvar i = 0; i < NPROG; i++) begin : g_hit
    assign hit[i] = ~(sel_prog[i] ^ pol_strap[i]);
  end

  always_comb begin
    sel.prog_sel = &hit;
    sel.all_sel  = (&hit) & ~sel_fixed_n;
  end
endmodule

// File: rtl/sram_fe_burst.sv
module sram_fe_burst #(
  parameter int ADDR_W    = 16,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ok,
  input  logic              advance,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              beat_ok
);
  localparam int BW = $clog2(BURST_LEN);
  localparam logic [BW-1:0] LAST_BEAT = BW'(BURST_LEN - 1);
  localparam logic [BW-1:0] ONE       = BW'(1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BW-1:0]     rem_q, rem_d;
  logic              addr_en, rem_en;

  always_comb begin
    addr_d  = addr_q;
    rem_d   = rem_q;
    addr_en = load_ok | advance;
    rem_en  = load_ok | (advance & (rem_q != '0));
    if (load_ok) begin
      addr_d = addr_in;
      rem_d  = LAST_BEAT;
    end else if (advance) begin
      addr_d[BW-1:0] = addr_q[BW-1:0] + ONE;
      if (rem_q != '0) rem_d = rem_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (rem_en)  rem_q  <= rem_d;
    end
  end

  assign addr_out = addr_q;
  assign beat_ok  = load_ok | (advance & (rem_q != '0));
endmodule

// File: rtl/sram_fe_oe_pipe.sv
module sram_fe_oe_pipe #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_rest
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sram_frontend.sv
module sram_frontend
  import sram_fe_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NPROG      = 2,
  parameter int BURST_LEN  = 4,
  parameter int OE_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_cmd,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              sel_fixed_n,
  input  logic [NPROG-1:0]  sel_prog,
  input  logic [NPROG-1:0]  pol_strap,
  output logic [ADDR_W-1:0] addr_out,
  output logic              rd_valid,
  output logic              echo_oe
);
  localparam int PIPE_W = 2;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  sel_t              sel;
  logic              load_ok, advance, beat_ok;
  logic [PIPE_W-1:0] pipe_d, pipe_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sram_fe_en_decode #(.NPROG(NPROG)) u_dec (
    .sel_fixed_n (sel_fixed_n),
    .sel_prog    (sel_prog),
    .pol_strap   (pol_strap),
    .sel         (sel)
  );

  assign load_ok = ld_cmd & sel.all_sel;
  assign advance = ~ld_cmd;

  sram_fe_burst #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_burst (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_ok  (load_ok),
    .advance  (advance),
    .addr_in  (addr_in),
    .addr_out (addr_out),
    .beat_ok  (beat_ok)
  );

  // data valid and echo enable share one pipeline so they align
  assign pipe_d = {sel.prog_sel, beat_ok};

  sram_fe_oe_pipe #(.STAGES(OE_STAGES), .W(PIPE_W)) u_pipe (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (pipe_d),
    .q     (pipe_q)
  );

  assign rd_valid = pipe_q[0];
  assign echo_oe  = pipe_q[1];
endmodule

module sram_frontend_chk #(
  parameter int ADDR_W = 16,
  parameter int NPROG  = 2
) (
  input logic              clk,
  input logic              rst_i,
  input logic              ld_cmd,
  input logic [ADDR_W-1:0] addr_in,
  input logic              sel_fixed_n,
  input logic [NPROG-1:0]  sel_prog,
  input logic [NPROG-1:0]  pol_strap,
  input logic [ADDR_W-1:0] addr_out,
  input logic              echo_oe
);
  logic [1:0] age_q;
  logic       p_sel, a_sel;

  assign p_sel = (sel_prog == pol_strap);
  assign a_sel = p_sel & ~sel_fixed_n;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (ld_cmd && a_sel) |=> (addr_out == $past(addr_in)));

  // R6
  ignored_load_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (ld_cmd && !a_sel) |=> $stable(addr_out));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !ld_cmd |=> ((addr_out[1:0] == ($past(addr_out[1:0]) + 2'd1)) &&
                 (addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]))));

  // R8
  echo_delay_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (age_q >= 2'd2) |-> (echo_oe == $past(p_sel, 2)));
endmodule

bind sram_frontend sram_frontend_chk #(.ADDR_W(ADDR_W), .NPROG(NPROG)) u_chk (
  .clk         (clk),
  .rst_i       (rst_int_n),
  .ld_cmd      (ld_cmd),
  .addr_in     (addr_in),
  .sel_fixed_n (sel_fixed_n),
  .sel_prog    (sel_prog),
  .pol_strap   (pol_strap),
  .addr_out    (addr_out),
  .echo_oe     (echo_oe)
);

// File: tb/tb_sram_frontend.sv
`timescale 1ns/1ps
module tb_sram_frontend;
  localparam int AW = 16;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_cmd;
  logic [AW-1:0] addr_in;
  logic          sel_fixed_n;
  logic [NP-1:0] sel_prog, pol_strap;
  logic [AW-1:0] addr_out;
  logic          rd_valid, echo_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sram_frontend dut (
    .clk(clk), .rst_n(rst_n), .ld_cmd(ld_cmd), .addr_in(addr_in),
    .sel_fixed_n(sel_fixed_n), .sel_prog(sel_prog), .pol_strap(pol_strap),
    .addr_out(addr_out), .rd_valid(rd_valid), .echo_oe(echo_oe)
  );

  // reference model built from the requirements
  logic [1:0]    m_rs;
  logic [AW-1:0] m_addr;
  logic [1:0]    m_rem;
  logic [1:0]    m_v, m_e;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs <= '0; m_addr <= '0; m_rem <= '0; m_v <= '0; m_e <= '0;
    end else begin
      m_rs <= {m_rs[0], 1'b1};
      if (m_rs[1]) begin : upd
        logic ps, as, beat;
        ps   = (sel_prog == pol_strap);
        as   = ps && !sel_fixed_n;
        beat = (ld_cmd && as) || (!ld_cmd && m_rem != 0);
        if (ld_cmd && as) begin
          m_addr <= addr_in; m_rem <= 2'd3;
        end else if (!ld_cmd) begin
          m_addr[1:0] <= m_addr[1:0] + 2'd1;
          if (m_rem != 0) m_rem <= m_rem - 2'd1;
        end
        m_v <= {m_v[0], beat};
        m_e <= {m_e[0], ps};
      end
    end
  end

  function automatic logic [AW-1:0] burst_addr(logic [AW-1:0] base, int k);
    logic [AW-1:0] r;
    r = base;
    r[1:0] = base[1:0] + 2'(k);
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // apply inputs after a falling edge, then sample at the next falling edge
  task automatic step(logic ld, logic [AW-1:0] a, logic fn, logic [NP-1:0] ep, logic [NP-1:0] st);
    ld_cmd = ld; addr_in = a; sel_fixed_n = fn; sel_prog = ep; pol_strap = st;
    @(posedge clk); @(negedge clk);
    check("R3 addr", 32'(addr_out), 32'(m_addr));
    check("R7 rd_valid", 32'(rd_valid), 32'(m_v[1]));
    check("R8 echo_oe", 32'(echo_oe), 32'(m_e[1]));
  endtask

  task automatic idle();  // deselected load: no state change
    step(1'b1, '0, 1'b1, 2'b00, 2'b00);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] base, prev;
    void'($urandom(32'd20250611));
    rst_n = 1'b0; ld_cmd = 1'b1; addr_in = '0; sel_fixed_n = 1'b1;
    sel_prog = '0; pol_strap = '0;
    repeat (3) @(negedge clk);
    check("R1 addr", 32'(addr_out), 0);
    check("R1 rd_valid", 32'(rd_valid), 0);
    check("R1 echo_oe", 32'(echo_oe), 0);
    rst_n = 1'b1;
    repeat (4) idle();

    // R2 R3 R4: every starting offset
    for (int off = 0; off < 4; off++) begin
      base = AW'($urandom);
      base[1:0] = 2'(off);
      step(1'b1, base, 1'b0, 2'b10, 2'b10);
      check("R2 load", 32'(addr_out), 32'(base));
      for (int k = 1; k <= 4; k++) begin
        step(1'b0, AW'($urandom), 1'b1, 2'b01, 2'b10);
        check("R3 linear", 32'(addr_out), 32'(burst_addr(base, k)));
      end
      check("R4 wrap", 32'(addr_out), 32'(base));
      repeat (2) idle();
    end

    // R7: valid exactly two cycles after load, four beats
    step(1'b1, 16'h1232, 1'b0, 2'b00, 2'b00);
    check("R7 stage1", 32'(rd_valid), 0);
    step(1'b0, '0, 1'b0, 2'b00, 2'b00);
    check("R7 beat0", 32'(rd_valid), 1);
    step(1'b0, '0, 1'b0, 2'b00, 2'b00);
    step(1'b0, '0, 1'b0, 2'b00, 2'b00);
    step(1'b0, '0, 1'b0, 2'b00, 2'b00);
    check("R7 beat3", 32'(rd_valid), 1);
    step(1'b0, '0, 1'b0, 2'b00, 2'b00);
    check("R7 after", 32'(rd_valid), 0);

    // R5 R10: all strap codes against all select levels
    for (int b = 0; b < 4; b++) begin
      int hits;
      hits = 0;
      for (int s = 0; s < 4; s++) begin
        prev = addr_out;
        base = AW'(16'h4000 + b * 16 + s * 4 + 1);
        step(1'b1, base, 1'b0, 2'(b), 2'(s));
        check("R5 polarity", 32'(addr_out), (b == s) ? 32'(base) : 32'(prev));
        if (addr_out == base) hits++;
      end
      check("R10 one device", 32'(hits), 1);
    end

    // R6: fixed select off ignores load, no valid
    step(1'b1, 16'hAAA8, 1'b0, 2'b11, 2'b11);
    repeat (5) idle();
    step(1'b1, 16'h5554, 1'b1, 2'b11, 2'b11);
    check("R6 addr", 32'(addr_out), 32'h0000AAA8);
    idle();
    check("R6 rd_valid", 32'(rd_valid), 0);

    // R8: fixed deselect keeps echo, programmable deselect stops it 2 later
    step(1'b1, 16'h0, 1'b1, 2'b01, 2'b01);
    step(1'b1, 16'h0, 1'b1, 2'b01, 2'b01);
    check("R8 fixed off", 32'(echo_oe), 1);
    step(1'b1, 16'h0, 1'b0, 2'b00, 2'b01);
    check("R8 stage1", 32'(echo_oe), 1);
    step(1'b1, 16'h0, 1'b0, 2'b00, 2'b01);
    check("R8 prog off", 32'(echo_oe), 0);

    // R9: load during burst overrides
    step(1'b1, 16'h7771, 1'b0, 2'b00, 2'b00);
    step(1'b0, '0, 1'b0, 2'b00, 2'b00);
    step(1'b1, 16'h0F02, 1'b0, 2'b00, 2'b00);
    check("R9 override", 32'(addr_out), 32'h00000F02);
    for (int k = 1; k <= 4; k++) step(1'b0, '0, 1'b1, 2'b00, 2'b00);
    check("R9 rewrap", 32'(addr_out), 32'h00000F02);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [NP-1:0] st, ep;
      st = NP'($urandom);
      ep = (($urandom % 6) == 0) ? NP'($urandom) : st;
      step(($urandom % 3) == 0, AW'($urandom), ($urandom % 8) == 0, ep, st);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule